// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Duty-Triggered Commit

This block drives up to four independent pulse-width modulated outputs from one clock. Each channel owns a 32-byte window on a simple word-addressed write/read bus. In that window sit a clock divider setting, a period length in divided steps, a high-time length in divided steps, and a run bit. The output is high for the first part of every period and low for the rest.

Changes to period length and high time are staged. Writing the period length alone changes nothing on the pin. Writing the high time commits both staged values together. While a channel runs, the committed pair is adopted only when the period in progress ends, so no period ever mixes old and new settings. The divider setting is picked up at every period boundary. Clearing the run bit stops the pin at once and rewinds the counters, so the next start begins a fresh period.

Each channel is a two-state machine. The states are `CH_OFF` and `CH_RUN`. There are three named transitions:
- START: `CH_OFF` to `CH_RUN`, on a write of 1 to the run bit.
- STOP: `CH_RUN` to `CH_OFF`, on a write of 0 to the run bit.
- WRAP: `CH_RUN` to `CH_RUN`, at the last clock of a period, when staged values are adopted.

Top module: `pwm_bank`

## Requirements
- R1: The byte address of a register is its window offset plus the channel index shifted left by 5. The offsets are: divider at 0x00 (8 bits), period length M at 0x04 (8 bits), high time D at 0x08 (16 bits), and run at 0x18 (bit 0). A read returns the last value written, masked to the field width. Any other offset reads 0, and writes to it have no effect.
- R2: After reset every output is low and every register reads 0.
- R3: A running channel repeats a period of (P+1)·max(M,1) clocks, where P is the divider setting.
- R4: The output is high for the first (P+1)·D clocks of each period. If D ≥ M it stays high for the whole period, and if D = 0 it stays low.
- R5: Writing M without a later write of D leaves the running waveform unchanged.
- R6: A write of D commits the staged M and D. A running channel first finishes the period in progress with the old values, and the new values apply from the next period.
- R7: A new divider setting takes effect at the next period boundary, with no write of D needed.
- R8: Writing 0 to run forces the output low in the first clock after the write edge, mid-period included.
- R9: Writing 1 to run starts the channel at count zero in the first clock after the write edge. It uses the committed M and D and the current divider setting.
- R10: Each channel's registers and output are independent of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 7 | Byte address: channel index in the upper bits, register offset in the lower 5 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The assertions assume at most one register write per cycle. They also assume that a START or STOP is driven only by a write to the run offset of a channel index below the channel count. The stimulus issues every write through a single task that holds the strobe for exactly one clock, so these conditions always hold.

The sweeps cover small values of the divider, period length and high time. This keeps every expected waveform short enough to compare over two full periods. Mid-period writes are placed at cycle counts the bench tracks from each START, so commit and boundary timing is predicted arithmetically.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Register offsets inside one channel window
    localparam int unsigned OFF_PRESC = 32'h00;
    localparam int unsigned OFF_MOD   = 32'h04;
    localparam int unsigned OFF_DUTY  = 32'h08;
    localparam int unsigned OFF_RUN   = 32'h18;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_e;

endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec #(
    parameter int NUM_CH    = 4,
    parameter int WIN_SHIFT = 5,
    parameter int CH_W      = 2,
    parameter int ADDR_W    = WIN_SHIFT + CH_W
) (
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_CH-1:0]    wr_presc,
    output logic [NUM_CH-1:0]    wr_mod,
    output logic [NUM_CH-1:0]    wr_duty,
    output logic [NUM_CH-1:0]    wr_run,
    output logic [CH_W-1:0]      sel_ch,
    output logic                 sel_ok,
    output logic [WIN_SHIFT-1:0] sel_off
);
    import pwm_bank_pkg::*;

    assign sel_ch  = bus_addr[ADDR_W-1:WIN_SHIFT];
    assign sel_off = bus_addr[WIN_SHIFT-1:0];
    assign sel_ok  = (int'(sel_ch) < NUM_CH);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
        logic hit;
        assign hit          = bus_wr && sel_ok && (int'(sel_ch) == ch);
        assign wr_presc[ch] = hit && (sel_off == WIN_SHIFT'(OFF_PRESC));
        assign wr_mod[ch]   = hit && (sel_off == WIN_SHIFT'(OFF_MOD));
        assign wr_duty[ch]  = hit && (sel_off == WIN_SHIFT'(OFF_DUTY));
        assign wr_run[ch]   = hit && (sel_off == WIN_SHIFT'(OFF_RUN));
    end

endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs #(
    parameter int PRE_W  = 8,
    parameter int MOD_W  = 8,
    parameter int DUTY_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_presc,
    input  logic              wr_mod,
    input  logic              wr_duty,
    input  logic              wr_run,
    input  logic [DATA_W-1:0] wdata,
    output logic [PRE_W-1:0]  presc_q,
    output logic [MOD_W-1:0]  mod_q,
    output logic [MOD_W-1:0]  mod_commit,
    output logic [DUTY_W-1:0] duty_q,
    output logic              run_q,
    output logic              run_next,
    output logic              commit
);

    // Staged values; the committed pair is mod_commit plus duty_q
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q    <= '0;
            mod_q      <= '0;
            mod_commit <= '0;
            duty_q     <= '0;
            run_q      <= 1'b0;
        end else begin
            if (wr_presc) presc_q <= wdata[PRE_W-1:0];
            if (wr_mod)   mod_q   <= wdata[MOD_W-1:0];
            if (wr_duty) begin
                duty_q     <= wdata[DUTY_W-1:0];
                mod_commit <= mod_q;
            end
            if (wr_run)   run_q   <= wdata[0];
        end
    end

    assign run_next = wr_run ? wdata[0] : run_q;
    assign commit   = wr_duty;

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
    parameter int PRE_W  = 8,
    parameter int MOD_W  = 8,
    parameter int DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_next,
    input  logic              commit,
    input  logic [PRE_W-1:0]  presc_q,
    input  logic [MOD_W-1:0]  mod_commit,
    input  logic [DUTY_W-1:0] duty_q,
    output logic              pwm_o,
    output logic              running,
    output logic              wrap,
    output logic [DUTY_W-1:0] duty_act
);
    import pwm_bank_pkg::*;

    ch_state_e        state_q, state_d;
    logic [PRE_W-1:0] pre_cnt, presc_act;
    logic [MOD_W-1:0] step_cnt, mod_act, step_last;
    logic             pending, tick;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Next state: START, STOP, WRAP (stays in CH_RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: if (run_next)  state_d = CH_RUN;
            CH_RUN: if (!run_next) state_d = CH_OFF;
            default: state_d = CH_OFF;
        endcase
    end

    assign step_last = (mod_act == '0) ? '0 : mod_act - 1'b1;
    assign tick      = (pre_cnt == presc_act);
    assign wrap      = (state_q == CH_RUN) && tick && (step_cnt == step_last);

    // Counters and active settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt   <= '0;
            step_cnt  <= '0;
            presc_act <= '0;
            mod_act   <= '0;
            duty_act  <= '0;
            pending   <= 1'b0;
        end else begin
            unique case (state_q)
                CH_OFF: begin
                    pre_cnt   <= '0;
                    step_cnt  <= '0;
                    presc_act <= presc_q;
                    mod_act   <= mod_commit;
                    duty_act  <= duty_q;
                    pending   <= commit;
                end
                CH_RUN: begin
                    if (!run_next) begin
                        pre_cnt  <= '0;
                        step_cnt <= '0;
                        pending  <= commit | pending;
                    end else begin
                        if (tick) begin
                            pre_cnt <= '0;
                            if (wrap) begin
                                step_cnt  <= '0;
                                presc_act <= presc_q;
                                if (pending) begin
                                    mod_act  <= mod_commit;
                                    duty_act <= duty_q;
                                end
                            end else begin
                                step_cnt <= step_cnt + 1'b1;
                            end
                        end else begin
                            pre_cnt <= pre_cnt + 1'b1;
                        end
                        pending <= commit | (pending & ~wrap);
                    end
                end
                default: pending <= 1'b0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        running = (state_q == CH_RUN);
        pwm_o   = 1'b0;
        unique case (state_q)
            CH_OFF: pwm_o = 1'b0;
            CH_RUN: pwm_o = (DUTY_W'(step_cnt) < duty_act);
            default: pwm_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
    parameter int NUM_CH    = 4,
    parameter int PRE_W     = 8,
    parameter int MOD_W     = 8,
    parameter int DUTY_W    = 16,
    parameter int DATA_W    = 32,
    parameter int WIN_SHIFT = 5,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W   = WIN_SHIFT + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    import pwm_bank_pkg::*;

    logic [NUM_CH-1:0]        wr_presc, wr_mod, wr_duty, wr_run;
    logic [4*NUM_CH-1:0]      wr_all;
    logic [CH_W-1:0]          sel_ch;
    logic                     sel_ok;
    logic [WIN_SHIFT-1:0]     sel_off;
    logic [NUM_CH-1:0]        ch_en, ch_run, ch_wrap;
    logic [NUM_CH*DUTY_W-1:0] ch_duty;

    logic [PRE_W-1:0]  rd_presc [NUM_CH];
    logic [MOD_W-1:0]  rd_mod   [NUM_CH];
    logic [DUTY_W-1:0] rd_duty  [NUM_CH];

    assign wr_all = {wr_presc, wr_mod, wr_duty, wr_run};

    pwm_addr_dec #(
        .NUM_CH(NUM_CH), .WIN_SHIFT(WIN_SHIFT), .CH_W(CH_W), .ADDR_W(ADDR_W)
    ) u_dec (
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .wr_presc(wr_presc), .wr_mod(wr_mod), .wr_duty(wr_duty), .wr_run(wr_run),
        .sel_ch(sel_ch), .sel_ok(sel_ok), .sel_off(sel_off)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [MOD_W-1:0] mod_commit;
        logic             run_next, commit;
        logic [DUTY_W-1:0] duty_act;

        pwm_chan_regs #(
            .PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W), .DATA_W(DATA_W)
        ) u_regs (
            .clk(clk), .rst_n(rst_n),
            .wr_presc(wr_presc[ch]), .wr_mod(wr_mod[ch]),
            .wr_duty(wr_duty[ch]), .wr_run(wr_run[ch]),
            .wdata(bus_wdata),
            .presc_q(rd_presc[ch]), .mod_q(rd_mod[ch]), .mod_commit(mod_commit),
            .duty_q(rd_duty[ch]), .run_q(ch_en[ch]),
            .run_next(run_next), .commit(commit)
        );

        pwm_chan_core #(
            .PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)
        ) u_core (
            .clk(clk), .rst_n(rst_n),
            .run_next(run_next), .commit(commit),
            .presc_q(rd_presc[ch]), .mod_commit(mod_commit), .duty_q(rd_duty[ch]),
            .pwm_o(pwm_out[ch]), .running(ch_run[ch]), .wrap(ch_wrap[ch]),
            .duty_act(duty_act)
        );

        assign ch_duty[ch*DUTY_W +: DUTY_W] = duty_act;
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (sel_ok) begin
            if (sel_off == WIN_SHIFT'(OFF_PRESC))
                bus_rdata = DATA_W'(rd_presc[sel_ch]);
            else if (sel_off == WIN_SHIFT'(OFF_MOD))
                bus_rdata = DATA_W'(rd_mod[sel_ch]);
            else if (sel_off == WIN_SHIFT'(OFF_DUTY))
                bus_rdata = DATA_W'(rd_duty[sel_ch]);
            else if (sel_off == WIN_SHIFT'(OFF_RUN))
                bus_rdata = DATA_W'(ch_en[sel_ch]);
        end
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NUM_CH    = 4,
    parameter int DUTY_W    = 16,
    parameter int DATA_W    = 32,
    parameter int WIN_SHIFT = 5,
    parameter int ADDR_W    = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [NUM_CH-1:0]        pwm_out,
    input logic [NUM_CH-1:0]        ch_en,
    input logic [NUM_CH-1:0]        ch_run,
    input logic [NUM_CH-1:0]        ch_wrap,
    input logic [NUM_CH*DUTY_W-1:0] ch_duty,
    input logic [4*NUM_CH-1:0]      wr_all
);
    import pwm_bank_pkg::*;

    assert_reset_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_out == '0));

    assert_dec_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_all));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic [ADDR_W-1:0] run_addr;
        assign run_addr = ADDR_W'((i << WIN_SHIFT) + OFF_RUN);

        assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |-> !pwm_out[i]);

        assert_stop_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == run_addr && !bus_wdata[0]) |=> !pwm_out[i]);

        assert_commit_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_run[i] && $past(ch_run[i]) &&
             ch_duty[i*DUTY_W +: DUTY_W] != $past(ch_duty[i*DUTY_W +: DUTY_W]))
            |-> $past(ch_wrap[i]));
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .DATA_W(DATA_W),
    .WIN_SHIFT(WIN_SHIFT), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pwm_out(pwm_out), .ch_en(ch_en), .ch_run(ch_run),
    .ch_wrap(ch_wrap), .ch_duty(ch_duty), .wr_all(wr_all)
);

// File: tb/sim_pwm_bank.sv
`timescale 1ns/1ps
module sim_pwm_bank;

    localparam int OP = 'h00, OM = 'h04, OD = 'h08, OE = 'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, want);
        end
    endtask

    // Called at a negedge; returns at the next negedge, after the write edge
    task automatic wr(input int ch, input int off, input int val);
        bus_wr    = 1'b1;
        bus_addr  = 7'((ch << 5) + off);
        bus_wdata = val;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int ch, input int off, output int val);
        bus_addr = 7'((ch << 5) + off);
        #1;
        val = bus_rdata;
        @(negedge clk);
    endtask

    task automatic setup(input int ch, input int p, input int m, input int d);
        wr(ch, OE, 0);
        wr(ch, OP, p);
        wr(ch, OM, m);
        wr(ch, OD, d);
        wr(ch, OE, 1);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        chk(pwm_out == 4'b0, "R2 outputs", int'(pwm_out), 0);
        for (int o = 0; o < 4; o++) begin
            int offs [4] = '{OP, OM, OD, OE};
            rd(0, offs[o], v);
            chk(v == 0, "R2 register", v, 0);
        end

        // R1: masked read-back, unmapped offset; R10: other window untouched
        wr(3, OP, 'h1AB);
        wr(3, OM, 'h1FF);
        wr(3, OD, 'h12345);
        wr(3, OE, 'h2);
        wr(3, 'h0C, 'h55);
        rd(3, OP, v);   chk(v == 'hAB, "R1 divider", v, 'hAB);
        rd(3, OM, v);   chk(v == 'hFF, "R1 period", v, 'hFF);
        rd(3, OD, v);   chk(v == 'h2345, "R1 high time", v, 'h2345);
        rd(3, OE, v);   chk(v == 0, "R1 run", v, 0);
        rd(3, 'h0C, v); chk(v == 0, "R1 unmapped", v, 0);
        rd(1, OP, v);   chk(v == 0, "R10 other window", v, 0);
        chk(pwm_out == 4'b0, "R1 unmapped write no output", int'(pwm_out), 0);

        // R3 R4 R9 R10: sweep of small settings, fresh start each time
        for (int p = 0; p < 3; p++) begin
            for (int m = 0; m < 6; m++) begin
                for (int d = 0; d < 7; d++) begin
                    int ch, meff, per, mism, other, got1, want1;
                    ch = (p * 42 + m * 7 + d) % 4;
                    meff = (m == 0) ? 1 : m;
                    per = (p + 1) * meff;
                    mism = 0; other = 0; got1 = 0; want1 = 0;
                    setup(ch, p, m, d);
                    for (int i = 0; i < 2 * per; i++) begin
                        int want;
                        want = (((i % per) / (p + 1)) < d) ? 1 : 0;
                        if (int'(pwm_out[ch]) != want && mism == 0) begin
                            got1 = int'(pwm_out[ch]);
                            want1 = want;
                        end
                        if (int'(pwm_out[ch]) != want) mism++;
                        if ((pwm_out & ~(4'b1 << ch)) != 4'b0) other++;
                        @(negedge clk);
                    end
                    chk(mism == 0, $sformatf("R3 R4 R9 p=%0d m=%0d d=%0d", p, m, d),
                        got1, want1);
                    chk(other == 0, "R10 other outputs", other, 0);
                    wr(ch, OE, 0);
                end
            end
        end

        // R5 R6: staged period length, commit on high-time write
        begin
            int errs5, errs6;
            errs5 = 0; errs6 = 0;
            setup(1, 0, 4, 2);            // pos0 now
            wr(1, OM, 6);                 // pos1
            for (int pos = 1; pos <= 8; pos++) begin
                if (int'(pwm_out[1]) != (((pos % 4) < 2) ? 1 : 0)) errs5++;
                @(negedge clk);
            end
            chk(errs5 == 0, "R5 period write alone", errs5, 0);
            wr(1, OD, 5);                 // pos10
            for (int pos = 10; pos <= 25; pos++) begin
                int want;
                want = (pos < 12) ? (((pos % 4) < 2) ? 1 : 0)
                                  : ((((pos - 12) % 6) < 5) ? 1 : 0);
                if (int'(pwm_out[1]) != want) errs6++;
                @(negedge clk);
            end
            chk(errs6 == 0, "R6 commit at period end", errs6, 0);
            wr(1, OE, 0);
        end

        // R7: divider picked up at the next boundary
        begin
            int errs;
            errs = 0;
            setup(2, 0, 4, 2);            // pos0
            wr(2, OP, 1);                 // pos1
            for (int pos = 1; pos <= 19; pos++) begin
                int want;
                want = (pos < 4) ? (((pos % 4) < 2) ? 1 : 0)
                                 : (((((pos - 4) % 8) / 2) < 2) ? 1 : 0);
                if (int'(pwm_out[2]) != want) errs++;
                @(negedge clk);
            end
            chk(errs == 0, "R7 divider at boundary", errs, 0);
            wr(2, OE, 0);
        end

        // R8: immediate stop; R9: fresh start afterwards
        begin
            int errs;
            setup(0, 3, 4, 4);
            repeat (5) @(negedge clk);
            chk(pwm_out[0] == 1'b1, "R4 full high", int'(pwm_out[0]), 1);
            wr(0, OE, 0);
            chk(pwm_out[0] == 1'b0, "R8 stop at once", int'(pwm_out[0]), 0);
            errs = 0;
            for (int i = 0; i < 6; i++) begin
                if (pwm_out[0] != 1'b0) errs++;
                @(negedge clk);
            end
            chk(errs == 0, "R8 stays low", errs, 0);
            wr(0, OP, 1);
            wr(0, OM, 3);
            wr(0, OD, 1);
            wr(0, OE, 1);
            errs = 0;
            for (int i = 0; i < 12; i++) begin
                if (int'(pwm_out[0]) != ((((i % 6) / 2) < 1) ? 1 : 0)) errs++;
                @(negedge clk);
            end
            chk(errs == 0, "R9 restart from zero", errs, 0);
            // stop mid-high, restart: must begin high again
            wr(0, OE, 0);
            wr(0, OE, 1);
            chk(pwm_out[0] == 1'b1, "R9 restart phase", int'(pwm_out[0]), 1);
            wr(0, OE, 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule